// File: doc/BRIEF.md
# Programmable Input Glitch Filter Bank

This block removes short glitches from a set of already-synchronized input lines. Each lane passes a level change only after its input has held the new value, without interruption, for a programmable number of clock cycles. Until then the filtered output keeps its previous value. Any cycle in which the input returns to the filtered value throws away the progress made so far.

Each lane has its own 12-bit configuration word. The word holds a 4-bit mantissa and a 4-bit power-of-two exponent. The required stable time is mantissa × 2^exponent clock edges, so one narrow field covers a range from a single clock up to 15 × 2^15 clocks. Internally, a prescaler produces a tick every 2^exponent clocks, and a stability counter counts ticks up to the mantissa. A mantissa of zero turns the filter off.

The package provides a default configuration word, with exponent 4 and mantissa 9. This gives a 144-clock window, which at a 2.5 ns clock is roughly 360 ns.

Top module: `glitch_filter_bank`

## Requirements
- R1: While `rst_n` is low, and after reset until an input change has been qualified, every bit of `pin_filt` is 0.
- R2: In each lane's 12-bit word `cfg[l*12 +: 12]`, bits 7:4 are the mantissa and bits 11:8 are the exponent. Bits 3:0 have no effect on filtering.
- R3: With mantissa M ≥ 1 and exponent E, let N = M × 2^E. If a lane's input changes and then holds, the output takes the new value at the N-th rising edge that samples the changed input, and not at any earlier edge.
- R4: The package default word (exponent 4, mantissa 9) gives a window of 144 edges.
- R5: Any edge that samples the input equal to the current output restarts the window. A pulse shorter than N edges never reaches the output, and separate short pulses do not add up.
- R6: With mantissa 0, a lane is unfiltered whatever its exponent: the output follows the input one edge later.
- R7: Rising and falling transitions are filtered with the same window.
- R8: Lanes are independent. Each lane uses only its own input and its own configuration word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | LANES | Synchronized input lines, one bit per lane |
| cfg | input | LANES*12 | Per-lane filter configuration words |
| pin_filt | output | LANES | Filtered lines |

## Verification
The assertions assume that `pin_in` is already synchronous to `clk`. They also assume that a lane's configuration changes only while that lane's input equals its output, so that no window is in progress when the word changes. The stimulus respects both. It changes inputs and configuration words only on falling clock edges. It reprograms a lane only after the lane's previous transition has settled. When it drives lanes at the same time, each lane's window runs against a configuration that stays fixed.

// File: rtl/gf_pkg.sv
package gf_pkg;
   localparam int GF_CNT_W   = 4;
   localparam int GF_SEL_W   = 4;
   localparam int GF_CFG_W   = 12;
   localparam int GF_CNT_LSB = 4;
   localparam int GF_SEL_LSB = 8;

   // default word: exponent 4, mantissa 9 -> 144 clocks
   localparam logic [GF_CFG_W-1:0] GF_DFLT_CFG =
      GF_CFG_W'((4 << GF_SEL_LSB) | (9 << GF_CNT_LSB));

   typedef struct packed {
      logic [GF_SEL_W-1:0] sel;
      logic [GF_CNT_W-1:0] cnt;
   } gf_cfg_t;
endpackage

// File: rtl/gf_prescale.sv
module gf_prescale #(
   parameter int SEL_W = 4,
   localparam int PRE_W = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] limit;

   always_comb begin
      span  = ((PRE_W+1)'(1) << sel_i) - (PRE_W+1)'(1);
      limit = span[PRE_W-1:0];
   end

   assign tick_o = (pre_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (clr_i || tick_o)  pre_q <= '0;
      else                       pre_q <= pre_q + PRE_W'(1);
   end

   // R3
   pre_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_q != '0) |-> ($past(pre_q) == pre_q - PRE_W'(1)));
endmodule

// File: rtl/gf_hold_counter.sv
module gf_hold_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             fire_o,
   output logic [CNT_W-1:0] count_o
);
   logic [CNT_W-1:0] stab_q;
   logic [CNT_W:0]   next_val;

   assign next_val = {1'b0, stab_q} + (CNT_W+1)'(1);
   assign fire_o   = tick_i && (next_val >= {1'b0, cnt_i});
   assign count_o  = stab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stab_q <= '0;
      else if (clr_i)   stab_q <= '0;
      else if (tick_i)  stab_q <= next_val[CNT_W-1:0];
   end

   // R3
   advance_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stab_q != $past(stab_q)) && (stab_q != '0)) |-> $past(tick_i));
endmodule

// File: rtl/gf_lane.sv
module gf_lane
   import gf_pkg::*;
#(
   parameter int CNT_W = GF_CNT_W,
   parameter int SEL_W = GF_SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             filt_o
);
   logic             filt_q;
   logic             diff;
   logic             tick;
   logic             hc_fire;
   logic             take;
   logic             clr;
   logic [CNT_W-1:0] hold_cnt;

   assign diff = (din_i != filt_q);
   assign take = diff && ((cnt_i == '0) || hc_fire);
   assign clr  = !diff || take;

   generate
      if (SEL_W == 0) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         gf_prescale #(.SEL_W(SEL_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .sel_i  (sel_i),
            .tick_o (tick)
         );
      end
   endgenerate

   gf_hold_counter #(.CNT_W(CNT_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .tick_i  (tick),
      .cnt_i   (cnt_i),
      .fire_o  (hc_fire),
      .count_o (hold_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     filt_q <= 1'b0;
      else if (take)  filt_q <= din_i;
   end

   assign filt_o = filt_q;

   // R5
   change_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> (filt_q == $past(din_i)));
   // R5
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diff |=> $stable(filt_q));
   // R5
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diff |=> (hold_cnt == '0));
   // R6
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (diff && (cnt_i == '0)) |=> (filt_q == $past(din_i)));
endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
   import gf_pkg::*;
#(
   parameter int LANES   = 2,
   parameter int CNT_W   = GF_CNT_W,
   parameter int SEL_W   = GF_SEL_W,
   parameter int CFG_W   = GF_CFG_W,
   parameter int CNT_LSB = GF_CNT_LSB,
   parameter int SEL_LSB = GF_SEL_LSB
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       pin_in,
   input  logic [LANES*CFG_W-1:0] cfg,
   output logic [LANES-1:0]       pin_filt
);
   localparam int CNT_MSB = CNT_LSB + CNT_W - 1;
   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (SEL_W > 5) begin : g_bad_sel
         $error("SEL_W above 5 makes the prescaler too wide");
      end
      if ((CNT_MSB >= CFG_W) || (SEL_MSB >= CFG_W)) begin : g_bad_fit
         $error("configuration fields exceed the word");
      end
      if (!((CNT_MSB < SEL_LSB) || (SEL_MSB < CNT_LSB))) begin : g_bad_overlap
         $error("configuration fields overlap");
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [CFG_W-1:0] word;
         logic [CNT_W-1:0] cnt_f;
         logic [SEL_W-1:0] sel_f;

         assign word  = cfg[l*CFG_W +: CFG_W];
         assign cnt_f = word[CNT_MSB:CNT_LSB];
         assign sel_f = word[SEL_MSB:SEL_LSB];

         gf_lane #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_i  (pin_in[l]),
            .cnt_i  (cnt_f),
            .sel_i  (sel_f),
            .filt_o (pin_filt[l])
         );
      end
   endgenerate
endmodule

// File: tb/tb_glitch_filter_bank.sv
module tb_glitch_filter_bank;
   import gf_pkg::*;

   localparam int LANES = 2;
   localparam int CW    = GF_CFG_W;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [LANES-1:0]    pin_in = '0;
   logic [LANES*CW-1:0] cfg = '0;
   logic [LANES-1:0]    pin_filt;

   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   bit  cur [LANES];

   typedef struct {
      int    at;
      int    lane;
      bit    val;
      string req;
   } exp_t;
   exp_t sb [$];

   glitch_filter_bank #(.LANES(LANES)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .cfg      (cfg),
      .pin_filt (pin_filt)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pop scoreboard entries whose cycle has come
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (pin_filt[e.lane] !== e.val) begin
            errors++;
            $display("FAIL %s: lane %0d cycle %0d actual %b expected %b",
                     e.req, e.lane, cyc, pin_filt[e.lane], e.val);
         end
      end
   end

   task automatic push(int at, int lane, bit val, string req);
      exp_t e;
      e.at = at; e.lane = lane; e.val = val; e.req = req;
      sb.push_back(e);
   endtask

   task automatic set_cfg(int lane, int sel, int cnt, int junk);
      cfg[lane*CW +: CW] = CW'((sel << 8) | (cnt << 4) | junk);
   endtask

   // toggle one lane and hold; output must flip exactly n edges later
   task automatic step(int lane, int n, string req);
      int c;
      bit v;
      c = cyc;
      v = !cur[lane];
      pin_in[lane] = v;
      if (n >= 2) push(c + n - 1, lane, !v, req);
      push(c + n, lane, v, req);
      cur[lane] = v;
      repeat (n + 2) @(negedge clk);
   endtask

   // pulse shorter than window n, then return
   task automatic glitch(int lane, int len, int n, string req);
      int c;
      c = cyc;
      push(c + len, lane, cur[lane], req);
      push(c + n + 2, lane, cur[lane], req);
      pin_in[lane] = !cur[lane];
      repeat (len) @(negedge clk);
      pin_in[lane] = cur[lane];
      repeat (n + 4 - len) @(negedge clk);
   endtask

   initial begin
      for (int l = 0; l < LANES; l++) cur[l] = 1'b0;
      for (int l = 0; l < LANES; l++) cfg[l*CW +: CW] = GF_DFLT_CFG;
      repeat (3) @(negedge clk);
      // R1 during reset
      checks++;
      if (pin_filt !== '0) begin
         errors++;
         $display("FAIL R1: actual %b expected 0", pin_filt);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if (pin_filt !== '0) begin
         errors++;
         $display("FAIL R1: actual %b expected 0", pin_filt);
      end

      // R4 default window, R3 exact edge, R7 both directions
      step(0, 144, "R4");
      step(0, 144, "R7");
      // R5 pulse one edge short of the window
      glitch(0, 143, 144, "R5");

      // R5 restart: near-full pulse, one low cycle, then hold
      set_cfg(0, 2, 3, 0);
      begin
         int c;
         c = cyc;
         push(c + 11, 0, 1'b0, "R5");
         push(c + 12, 0, 1'b0, "R5");
         pin_in[0] = 1'b1;
         repeat (11) @(negedge clk);
         pin_in[0] = 1'b0;
         @(negedge clk);
         step(0, 12, "R5");
      end

      // R3 mantissa only
      set_cfg(0, 0, 3, 0);
      step(0, 3, "R3");
      step(0, 3, "R7");
      // R2 low bits ignored
      set_cfg(0, 2, 1, 15);
      step(0, 4, "R2");
      set_cfg(0, 2, 1, 5);
      step(0, 4, "R2");
      // R6 mantissa zero bypasses, exponent irrelevant
      set_cfg(0, 7, 0, 0);
      step(0, 1, "R6");
      step(0, 1, "R6");
      // R3 larger settings
      set_cfg(0, 3, 15, 0);
      step(0, 120, "R3");
      set_cfg(0, 10, 5, 0);
      step(0, 5120, "R3");

      // R8 two lanes with different windows at once
      set_cfg(0, 4, 9, 0);
      set_cfg(1, 1, 2, 0);
      begin
         int c;
         c = cyc;
         pin_in[0] = !cur[0];
         pin_in[1] = !cur[1];
         push(c + 3, 1, cur[1], "R8");
         push(c + 4, 1, !cur[1], "R8");
         push(c + 4, 0, cur[0], "R8");
         push(c + 143, 0, cur[0], "R8");
         push(c + 144, 0, !cur[0], "R8");
         cur[0] = !cur[0];
         cur[1] = !cur[1];
         repeat (150) @(negedge clk);
      end

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule